// File: doc/BRIEF.md
# Hit Frame Store with Serial Readout

This block records the discriminator hit map of a 64-channel front end while an acquisition window is open. Each channel has two thresholds, which gives 128 hit bits per bunch clock. On any clock inside the window where at least one of those bits is set, the block stores one frame. A frame is an 8-bit header value, the 24-bit bunch-crossing identifier of that clock, and the 128 hit bits. The memory holds up to 128 frames.

Once the window closes, an external sequencer pulses a readout strobe. Each strobe shifts one bit of the stored data onto a single serial line, with a data-valid flag beside it. Frames come out in the order they were written. When the last stored bit has left, an end-of-readout pulse marks it, and the memory is empty again for the next window. The bunch-crossing identifier counts every bunch clock since the window opened and wraps at 24 bits.

Top module: `hit_frame_store`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sdo_vld`, `rd_done` and `mem_full` are low.
- R2: A frame is stored on a rising clock edge where `acq_en` is high and at least one bit of `hits` is set. Hitless cycles store nothing, and hits presented while `acq_en` is low store nothing.
- R3: The stored identifier is the number of clock edges since the window opened. The edge at which `acq_en` is first seen high carries 0, and the count advances on every edge of the window, including hitless ones.
- R4: Each frame is sent in this order. First `hdr`, MSB first. Then the identifier, MSB first. Then `hits[0]` to `hits[63]`, which are the first-threshold bits of channels 0 to 63. Then `hits[64]` to `hits[127]`, which are the second-threshold bits of channels 0 to 63. That is 160 bits per frame.
- R5: Each clock edge that sees `rd_stb` high, with the window closed and frames stored, puts exactly one bit on `sdo`. `sdo_vld` is high for that bit in the following cycle and low in every other cycle.
- R6: Frames are read out in the order they were written, and exactly the stored number of frames is sent.
- R7: `mem_full` rises once 128 frames are stored and stays high for the rest of the window. Hits after that are dropped and leave the stored frames unchanged.
- R8: `rd_done` is high for exactly one cycle, together with the valid of the last stored bit. From then on `mem_full` is low and further strobes send nothing.
- R9: `rd_stb` is ignored while `acq_en` is high.
- R10: Opening a window discards any frames that were not read out. The new window starts from an empty memory and from identifier 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition window open |
| hits | input | 128 | Bits 0..63 first threshold, 64..127 second threshold, bit index within each half = channel |
| hdr | input | 8 | Header byte stored with each frame |
| rd_stb | input | 1 | Readout strobe, one bit per high cycle |
| sdo | output | 1 | Serial data |
| sdo_vld | output | 1 | `sdo` carries a valid bit |
| mem_full | output | 1 | 128 frames stored |
| rd_done | output | 1 | Last stored bit is on `sdo` |

## Verification
A frame write takes effect at the edge that samples `acq_en` and `hits`, so `mem_full` is checked just after that same edge. Every serial bit, and the `rd_done` that goes with it, appears one edge after the edge that samples `rd_stb`. The bench therefore drives inputs 1 ns after a rising edge and checks each output 1 ns after the next edge. Gap cycles without a strobe are checked for a low `sdo_vld` in the same way. The expected frame list is built from the window stimulus as it is driven, with the identifier taken from the bench's own cycle index inside the window.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

    localparam int HFS_NCH    = 64;
    localparam int HFS_NTHR   = 2;
    localparam int HFS_HITW   = HFS_NCH * HFS_NTHR;
    localparam int HFS_BCW    = 24;
    localparam int HFS_HDRW   = 8;
    localparam int HFS_DEPTH  = 128;
    localparam int HFS_FRAMEW = HFS_HDRW + HFS_BCW + HFS_HITW;
    localparam int HFS_PTRW   = $clog2(HFS_FRAMEW);

    typedef struct packed {
        logic [HFS_HDRW-1:0] hdr;
        logic [HFS_BCW-1:0]  bcid;
        logic [HFS_HITW-1:0] hits;
    } hfs_frame_t;

    // Reorder a frame so that the bit sent first sits at the MSB:
    // header and identifier keep their MSB-first order, hit bits go
    // from index 0 upward.
    function automatic logic [HFS_FRAMEW-1:0] hfs_wire_order(hfs_frame_t f);
        logic [HFS_HITW-1:0] rev;
        for (int i = 0; i < HFS_HITW; i++) begin
            rev[HFS_HITW-1-i] = f.hits[i];
        end
        return {f.hdr, f.bcid, rev};
    endfunction

endpackage

// File: rtl/hfs_bcid_ctr.sv
module hfs_bcid_ctr
    import hfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acq_en,
    output logic               win_open,
    output logic [HFS_BCW-1:0] bcid_now
);

    logic               acq_q;
    logic [HFS_BCW-1:0] bc_q;

    assign win_open = acq_en && !acq_q;
    assign bcid_now = win_open ? '0 : bc_q + HFS_BCW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            acq_q <= 1'b0;
            bc_q  <= '0;
        end else begin
            acq_q <= acq_en;
            if (acq_en) begin
                bc_q <= bcid_now;
            end
        end
    end

endmodule

// File: rtl/hfs_frame_ram.sv
module hfs_frame_ram
    import hfs_pkg::*;
#(
    parameter int DEPTH = HFS_DEPTH,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  hfs_frame_t      wdata,
    input  logic [IDXW-1:0] raddr,
    output hfs_frame_t      rdata
);

    hfs_frame_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/hfs_serializer.sv
module hfs_serializer
    import hfs_pkg::*;
#(
    parameter int DEPTH = HFS_DEPTH,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            win_open,
    input  logic            acq_en,
    input  logic            rd_stb,
    input  logic [CNTW-1:0] count,
    input  hfs_frame_t      rdata,
    output logic [IDXW-1:0] raddr,
    output logic            last_now,
    output logic            sdo,
    output logic            sdo_vld,
    output logic            rd_done
);

    logic [HFS_PTRW-1:0]   bit_ptr;
    logic [IDXW-1:0]       frm_idx;
    logic [HFS_FRAMEW-1:0] wire_bits;
    logic [HFS_PTRW-1:0]   sel;
    logic                  fire;
    logic                  last_bit;
    logic                  last_frame;

    assign wire_bits  = hfs_wire_order(rdata);
    assign sel        = HFS_PTRW'(HFS_FRAMEW - 1) - bit_ptr;
    assign fire       = rd_stb && !acq_en && (count != '0);
    assign last_bit   = (bit_ptr == HFS_PTRW'(HFS_FRAMEW - 1));
    assign last_frame = (CNTW'(frm_idx) == count - CNTW'(1));
    assign last_now   = fire && last_bit && last_frame;
    assign raddr      = frm_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_ptr <= '0;
            frm_idx <= '0;
            sdo     <= 1'b0;
            sdo_vld <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            sdo_vld <= fire;
            rd_done <= last_now;
            if (fire) begin
                sdo <= wire_bits[sel];
            end
            if (win_open) begin
                bit_ptr <= '0;
                frm_idx <= '0;
            end else if (fire) begin
                if (last_bit) begin
                    bit_ptr <= '0;
                    frm_idx <= last_frame ? '0 : frm_idx + IDXW'(1);
                end else begin
                    bit_ptr <= bit_ptr + HFS_PTRW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/hit_frame_store.sv
module hit_frame_store
    import hfs_pkg::*;
#(
    parameter int DEPTH = HFS_DEPTH,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acq_en,
    input  logic [HFS_HITW-1:0] hits,
    input  logic [HFS_HDRW-1:0] hdr,
    input  logic                rd_stb,
    output logic                sdo,
    output logic                sdo_vld,
    output logic                mem_full,
    output logic                rd_done
);

    logic               win_open;
    logic [HFS_BCW-1:0] bcid_now;
    logic [CNTW-1:0]    count;
    logic [CNTW-1:0]    eff_cnt;
    logic               wr;
    logic [IDXW-1:0]    raddr;
    logic               last_now;
    hfs_frame_t         wdata;
    hfs_frame_t         rdata;

    hfs_bcid_ctr u_bcid (
        .clk      (clk),
        .rst      (rst),
        .acq_en   (acq_en),
        .win_open (win_open),
        .bcid_now (bcid_now)
    );

    // A newly opened window starts from an empty memory.
    assign eff_cnt  = win_open ? '0 : count;
    assign wr       = acq_en && (|hits) && (eff_cnt < CNTW'(DEPTH));
    assign wdata    = '{hdr: hdr, bcid: bcid_now, hits: hits};
    assign mem_full = (count == CNTW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (win_open) begin
            count <= wr ? CNTW'(1) : '0;
        end else if (last_now) begin
            count <= '0;
        end else if (wr) begin
            count <= count + CNTW'(1);
        end
    end

    hfs_frame_ram #(.DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr),
        .waddr (eff_cnt[IDXW-1:0]),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    hfs_serializer #(.DEPTH(DEPTH)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .win_open (win_open),
        .acq_en   (acq_en),
        .rd_stb   (rd_stb),
        .count    (count),
        .rdata    (rdata),
        .raddr    (raddr),
        .last_now (last_now),
        .sdo      (sdo),
        .sdo_vld  (sdo_vld),
        .rd_done  (rd_done)
    );

endmodule

// File: rtl/hfs_checker.sv
module hfs_checker (
    input logic clk,
    input logic rst,
    input logic acq_en,
    input logic rd_stb,
    input logic sdo_vld,
    input logic mem_full,
    input logic rd_done
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sdo_vld && !rd_done && !mem_full));

    a_r5_vld_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        sdo_vld |-> $past(rd_stb));

    a_r9_window_blocks_read: assert property (@(posedge clk) disable iff (rst)
        sdo_vld |-> !$past(acq_en));

    a_r8_done_with_bit: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> (sdo_vld && !mem_full));

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        (mem_full && acq_en && $past(acq_en)) |=> mem_full);

endmodule

bind hit_frame_store hfs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .acq_en   (acq_en),
    .rd_stb   (rd_stb),
    .sdo_vld  (sdo_vld),
    .mem_full (mem_full),
    .rd_done  (rd_done)
);

// File: tb/hit_frame_store_test.sv
module hit_frame_store_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         acq_en;
    logic [127:0] hits;
    logic [7:0]   hdr;
    logic         rd_stb;
    logic         sdo;
    logic         sdo_vld;
    logic         mem_full;
    logic         rd_done;

    int checks = 0;
    int errors = 0;

    logic [7:0]   q_hdr [$];
    logic [23:0]  q_bc  [$];
    logic [127:0] q_hit [$];

    always #2 clk = ~clk;

    hit_frame_store uut (
        .clk      (clk),
        .rst      (rst),
        .acq_en   (acq_en),
        .hits     (hits),
        .hdr      (hdr),
        .rd_stb   (rd_stb),
        .sdo      (sdo),
        .sdo_vld  (sdo_vld),
        .mem_full (mem_full),
        .rd_done  (rd_done)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Expected serial bit p of a frame, per R4.
    function automatic logic exp_bit(logic [7:0] h, logic [23:0] b, logic [127:0] ht, int p);
        if (p < 8)  return h[7-p];
        if (p < 32) return b[23-(p-8)];
        return ht[p-32];
    endfunction

    function automatic logic [127:0] gen_hits(int mode);
        int r;
        logic [127:0] v;
        r = int'($urandom % 4);
        if (mode == 1) r = 2 + int'($urandom % 2);
        v = '0;
        if (r == 1) v[$urandom % 128] = 1'b1;
        else if (r >= 2) v = {$urandom, $urandom, $urandom, $urandom};
        return v;
    endfunction

    // Open a window for n cycles; mode 1 makes every cycle carry hits.
    task automatic run_window(int n, int mode, bit strobe_in);
        q_hdr.delete(); q_bc.delete(); q_hit.delete();
        acq_en = 1'b1;
        rd_stb = strobe_in;
        for (int i = 0; i < n; i++) begin
            hdr  = 8'($urandom);
            hits = gen_hits(mode);
            if ((|hits) && q_hit.size() < 128) begin
                q_hdr.push_back(hdr);
                q_bc.push_back(24'(i));
                q_hit.push_back(hits);
            end
            step();
            check(32'(mem_full), 32'(q_hit.size() >= 128), "R7", "mem_full during window");
            if (strobe_in) check(32'(sdo_vld), 0, "R9", "strobe inside window");
        end
        acq_en = 1'b0;
        rd_stb = 1'b0;
        // Hits with the window closed must not be stored (R2).
        hits = {4{32'hFFFF_FFFF}};
        step();
        hits = {4{32'h0000_0001}};
        step();
        hits = '0;
    endtask

    task automatic readout(int gap_rate);
        int n;
        n = q_hit.size();
        for (int f = 0; f < n; f++) begin
            for (int p = 0; p < 160; p++) begin
                if (gap_rate > 0 && ($urandom % gap_rate) == 0) begin
                    rd_stb = 1'b0;
                    step();
                    check(32'(sdo_vld), 0, "R5", "vld without strobe");
                    check(32'(rd_done), 0, "R8", "done without strobe");
                end
                rd_stb = 1'b1;
                step();
                rd_stb = 1'b0;
                check(32'(sdo_vld), 1, "R5", "vld after strobe");
                check(32'(sdo), 32'(exp_bit(q_hdr[f], q_bc[f], q_hit[f], p)), "R4", $sformatf("frame %0d bit %0d (R6 R3)", f, p));
                check(32'(rd_done), 32'((f == n - 1) && (p == 159)), "R8", "done position");
            end
        end
        check(32'(mem_full), 0, "R8", "mem_full after readout");
        rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
        check(32'(sdo_vld), 0, "R8", "strobe after end (R2 R6)");
        check(32'(rd_done), 0, "R8", "no second done");
        q_hdr.delete(); q_bc.delete(); q_hit.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; acq_en = 1'b0; hits = '0; hdr = '0; rd_stb = 1'b0;
        repeat (3) step();
        check(32'(sdo_vld), 0, "R1", "vld in reset");
        check(32'(rd_done), 0, "R1", "done in reset");
        check(32'(mem_full), 0, "R1", "full in reset");
        rst = 1'b0;
        step();
        check(32'(sdo_vld), 0, "R1", "vld after reset");

        // Random window, strobe held inside it (R9), mixed hitless cycles (R2, R3).
        run_window(40, 0, 1'b1);
        readout(4);

        // Directed frame: single hits on first and last bit, header A5, id 3.
        q_hdr.delete(); q_bc.delete(); q_hit.delete();
        acq_en = 1'b1;
        hits = '0;
        repeat (3) step();
        hdr = 8'hA5; hits = '0; hits[0] = 1'b1; hits[127] = 1'b1;
        q_hdr.push_back(8'hA5); q_bc.push_back(24'd3); q_hit.push_back(hits);
        step();
        hits = '0;
        step();
        acq_en = 1'b0;
        step();
        readout(0);

        // Fill past capacity (R7).
        run_window(140, 1, 1'b0);
        check(32'(mem_full), 1, "R7", "full after window");
        readout(8);

        // Unread frames are dropped when a new window opens (R10).
        run_window(10, 1, 1'b0);
        run_window(6, 0, 1'b0);
        readout(3);

        // Window with no hits at all stores nothing (R2).
        run_window(5, 2, 1'b0);
        q_hdr.delete(); q_bc.delete(); q_hit.delete();
        acq_en = 1'b1; hits = '0;
        repeat (5) step();
        acq_en = 1'b0;
        step();
        rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
        check(32'(sdo_vld), 0, "R2", "hitless window read");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule